// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

A synthesizable, cycle-level model of a synchronous pipelined burst SRAM. Each word is 36 bits, split into four 9-bit byte lanes, and the depth is set by a parameter. Address, the three chip selects, the two access strobes, the advance input and the write controls are all sampled on the rising clock edge. Output enable, burst ordering and sleep act without the clock.

Either strobe can open an access. The processor-side strobe always starts with a read and takes any write on the following edge. The controller-side strobe can write on the same edge it opens the access. A two-bit burst counter then walks four addresses in linear or interleaved order, driven by the advance input. Read data leaves through a two-register pipeline. A deselect stops the output drive at the very next edge.

The data bus is modelled as separate `din` and `dout` ports plus a drive flag, so there are no tristate pads.

Top module: `pipe_burst_sram`

## Requirements
- R1: An access opens on an edge where sleep is low, either strobe is active, and all three selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0). The presented address is loaded, and its two low bits become the burst start.
- R2: If both strobes are low, the processor strobe wins, so the access opens as a read and the write inputs are ignored. While `sel_a_n` is high the processor strobe is ignored altogether, so with the controller strobe high the edge is a burst continuation.
- R3: A write on a processor-strobe access happens on the next edge, a continuation edge. That edge uses the write controls and `din` sampled there.
- R4: When the controller strobe opens an access with write controls active, the write happens on that same edge at the presented address. `step_n` is ignored on that edge.
- R5: `all_wr_n`=0 writes all four lanes. Otherwise lane i (bits 9i+8:9i) is written only when `lane_wr_n`=0 and `lane_sel_n[i]`=0. With `lane_wr_n`=0 and every select high, the edge is a read.
- R6: A read on edge k puts the word on `dout` after edge k+1, with `drive_en` high if `out_en_n` is low. The word holds until the next edge.
- R7: On a continuation edge (both strobes inactive, device selected), `step_n`=0 moves to the next burst address and `step_n`=1 stays on the current one.
- R8: When `lin_order`=1 the low address bits are start+n mod 4. When `lin_order`=0 they are start XOR n.
- R9: An edge that sees a strobe but not all selects active deselects the device, and `drive_en` is low right after it. After an access opens from the deselected state, `drive_en` stays low for the first cycle.
- R10: `drive_en` is low whenever `out_en_n` is high, with no clock involved. It is also low for the cycle after any write edge.
- R11: While `sleep` is high, `drive_en` is low at once, strobes and writes are ignored, and the array keeps its contents.
- R12: Reset leaves the device deselected with `dout`=0 and `drive_en` low. Continuation edges after reset perform no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Active-low select, also gates the processor strobe |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| cpu_strobe_n | input | 1 | Processor-side access strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side access strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write every lane, active low |
| lane_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data from the output register |
| drive_en | output | 1 | High when the bus would be driven |

## Verification
The bench sets both strobes low while a full write is presented. A design that gave the controller strobe priority would overwrite the word, and the following burst read would show all ones. It runs a full linear burst across the wrap and an interleaved burst from start 3. An adder/XOR mix-up or a missing wrap puts the wrong word on a known cycle. It checks a deselect that arrives while a read is still in flight, and a first cycle after reselection. A two-cycle deselect or a missing first-cycle blank would show `drive_en` high there. It also checks a processor-strobe access that is ignored because `sel_a_n` is high and must carry on the burst, and a write made during sleep that must not reach the array.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   localparam int BURST_BITS = 2;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // Low address bits for beat n of a burst that began at 'start'.
   function automatic logic [BURST_BITS-1:0] burst_low(
      input logic [BURST_BITS-1:0] start,
      input logic [BURST_BITS-1:0] beat,
      input logic                  linear);
      return linear ? (start + beat) : (start ^ beat);
   endfunction

endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic              lin_order,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [HI_W-1:0]       hi_q;
   logic [BURST_BITS-1:0] start_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] beat_nx;

   assign beat_nx = beat_q + 1'b1;

   always_comb begin
      if (load)
         acc_addr = ext_addr;
      else if (advance)
         acc_addr = {hi_q, burst_low(start_q, beat_nx, lin_order)};
      else
         acc_addr = {hi_q, burst_low(start_q, beat_q, lin_order)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         start_q <= '0;
         beat_q  <= '0;
      end else if (load) begin
         hi_q    <= ext_addr[ADDR_W-1:BURST_BITS];
         start_q <= ext_addr[BURST_BITS-1:0];
         beat_q  <= '0;
      end else if (advance) begin
         beat_q  <= beat_nx;
      end
   end

endmodule

// File: rtl/pbs_lane_decode.sv
module pbs_lane_decode #(
   parameter int LANES = 4
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = !all_wr_n || (!lane_wr_n && !lane_sel_n[g]);
   end

endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        we,
   input  logic                    rd,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g])
            mem[addr] <= wdata[g*LANE_W +: LANE_W];
         if (rd)
            rdata[g*LANE_W +: LANE_W] <= mem[addr];
      end
   end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    cpu_strobe_n,
   input  logic                    ctl_strobe_n,
   input  logic                    step_n,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    out_en_n,
   input  logic                    lin_order,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    drive_en
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= BURST_BITS) begin : g_bad_addr
      $error("pipe_burst_sram: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("pipe_burst_sram: LANES and LANE_W must be positive");
   end

   logic              all_sel;
   logic              cpu_hit;
   logic              any_strobe;
   logic              start;
   logic              desel;
   logic              cont;
   logic              wr_req;
   logic              acc_wr;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] rd_word;
   acc_e              acc;

   logic              active_q;
   logic              v1_q;
   logic              v2_q;
   logic [DATA_W-1:0] dout_q;

   // Edge classification
   assign all_sel    = !sel_a_n && sel_b && !sel_c_n;
   assign cpu_hit    = !cpu_strobe_n && !sel_a_n;
   assign any_strobe = cpu_hit || !ctl_strobe_n;
   assign start      = !sleep && any_strobe && all_sel;
   assign desel      = !sleep && any_strobe && !all_sel;
   assign cont       = !sleep && !any_strobe && active_q;
   assign wr_req     = |lane_we;

   always_comb begin
      acc = ACC_IDLE;
      if (start)
         acc = (!cpu_hit && wr_req) ? ACC_WRITE : ACC_READ;
      else if (cont)
         acc = wr_req ? ACC_WRITE : ACC_READ;
   end

   assign acc_wr = (acc == ACC_WRITE);

   pbs_lane_decode #(.LANES(LANES)) u_decode (
      .all_wr_n   (all_wr_n),
      .lane_wr_n  (lane_wr_n),
      .lane_sel_n (lane_sel_n),
      .lane_we    (lane_we)
   );

   pbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .advance   (cont && !step_n),
      .lin_order (lin_order),
      .ext_addr  (addr),
      .acc_addr  (acc_addr)
   );

   pbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk   (clk),
      .addr  (acc_addr),
      .we    (acc_wr ? lane_we : '0),
      .rd    (acc == ACC_READ),
      .wdata (din),
      .rdata (rd_word)
   );

   // Select state and two-stage output pipeline
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         v1_q     <= 1'b0;
         v2_q     <= 1'b0;
         dout_q   <= '0;
      end else begin
         if (desel)
            active_q <= 1'b0;
         else if (start)
            active_q <= 1'b1;
         v1_q <= (acc == ACC_READ);
         v2_q <= v1_q && !desel && !acc_wr && !sleep;
         if (v1_q)
            dout_q <= rd_word;
      end
   end

   assign dout     = dout_q;
   assign drive_en = v2_q && !out_en_n && !sleep;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
   input logic clk,
   input logic rst_n,
   input logic sel_a_n,
   input logic sel_b,
   input logic sel_c_n,
   input logic cpu_strobe_n,
   input logic ctl_strobe_n,
   input logic sleep,
   input logic out_en_n,
   input logic drive_en,
   input logic active_q,
   input logic acc_wr
);

   logic strobe_seen;
   logic sel_ok;

   assign strobe_seen = (!cpu_strobe_n && !sel_a_n) || !ctl_strobe_n;
   assign sel_ok      = !sel_a_n && sel_b && !sel_c_n;

   // R9: a deselect stops the drive at the next edge
   a_r9_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_seen && !sel_ok && !sleep) |=> !drive_en);

   // R9: first cycle after opening from deselected is blank
   a_r9_first_cycle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && strobe_seen && sel_ok && !sleep) |=> !drive_en);

   // R10: output enable high blocks the drive
   a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !drive_en);

   // R10: no drive in the cycle after a write edge
   a_r10_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> !drive_en);

   // R11: sleep blocks the drive
   a_r11_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !drive_en);

endmodule

bind pipe_burst_sram pbs_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sel_a_n      (sel_a_n),
   .sel_b        (sel_b),
   .sel_c_n      (sel_c_n),
   .cpu_strobe_n (cpu_strobe_n),
   .ctl_strobe_n (ctl_strobe_n),
   .sleep        (sleep),
   .out_en_n     (out_en_n),
   .drive_en     (drive_en),
   .active_q     (active_q),
   .acc_wr       (acc_wr)
);

// File: tb/test_pipe_burst_sram.sv
module test_pipe_burst_sram;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 36;

   typedef struct packed {
      logic [3:0]    req;
      logic [2:0]    sel;      // {sel_a_n, sel_b, sel_c_n}
      logic          cpu_n;
      logic          ctl_n;
      logic          step_n;
      logic          gw_n;
      logic          lw_n;
      logic [3:0]    ls_n;
      logic          oe_n;
      logic          lin;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic          exp_en;
      logic [DW-1:0] exp_q;
   } vec_t;

   localparam logic [DW-1:0] ONES = 36'hFFFFFFFFF;
   localparam logic [DW-1:0] D10  = 36'hA5A5A5A5A;
   localparam logic [DW-1:0] D11  = 36'h111111111;
   localparam logic [DW-1:0] D12  = 36'h222222222;
   localparam logic [DW-1:0] D13  = 36'h333333333;
   localparam logic [DW-1:0] M11N = D11 | 36'h007FC01FF; // lanes 0 and 2
   localparam logic [DW-1:0] M13N = D13 | 36'hFF8000000; // lane 3
   localparam logic [DW-1:0] Z    = 36'h0;
   localparam logic [2:0]    SOK  = 3'b010;
   localparam logic [2:0]    SB0  = 3'b000;
   localparam logic [2:0]    SA1  = 3'b110;
   localparam int N = 28;

   localparam vec_t TBL [N] = '{
      //  req  sel  cpu  ctl  stp  gw   lw   ls_n    oe   lin  addr   din   en   exp
      '{4'd4, SOK, 1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,  1'b1,1'b1,8'h10, D10, 1'b0, Z},    // R4 adv ignored
      '{4'd1, SOK, 1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,  1'b1,1'b1,8'h11, D11, 1'b0, Z},    // R1
      '{4'd5, SOK, 1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,  1'b1,1'b1,8'h12, D12, 1'b0, Z},    // R5 global
      '{4'd5, SOK, 1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,  1'b1,1'b1,8'h13, D13, 1'b0, Z},    // R5
      '{4'd2, SOK, 1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,  1'b0,1'b1,8'h10, ONES,1'b0, Z},    // R2 both low
      '{4'd6, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, D10},  // R6
      '{4'd7, SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, D11},  // R7 suspend
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, D11},  // R8
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, D12},  // R8
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, D13},  // R8 wrap
      '{4'd9, SB0, 1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b0, Z},    // R9 deselect
      '{4'd9, SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b0, Z},    // R9 idle
      '{4'd3, SOK, 1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,  1'b1,1'b1,8'h11, ONES,1'b0, Z},    // R3 open
      '{4'd3, SOK, 1'b1,1'b1,1'b1,1'b1,1'b0,4'hA,  1'b1,1'b1,8'h00, ONES,1'b0, Z},    // R3 write
      '{4'd5, SOK, 1'b1,1'b1,1'b1,1'b1,1'b0,4'hF,  1'b0,1'b1,8'h00, Z,   1'b0, Z},    // R5 no lanes
      '{4'd3, SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b1,8'h00, Z,   1'b1, M11N}, // R3
      '{4'd4, SOK, 1'b1,1'b0,1'b1,1'b1,1'b0,4'h7,  1'b1,1'b1,8'h13, ONES,1'b0, Z},    // R4 lane 3
      '{4'd8, SOK, 1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h13, Z,   1'b0, Z},    // R8 interleaved
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, M13N}, // R8
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, D12},  // R8
      '{4'd8, SOK, 1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, M11N}, // R8
      '{4'd10,SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b1,1'b0,8'h00, Z,   1'b0, Z},    // R10 oe high
      '{4'd10,SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, D10},  // R10
      '{4'd2, SA1, 1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h40, Z,   1'b1, D10},  // R2 ignored
      '{4'd2, SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, M13N}, // R2
      '{4'd9, SA1, 1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b0, Z},    // R9
      '{4'd9, SOK, 1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h12, Z,   1'b0, Z},    // R9 first
      '{4'd6, SOK, 1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,  1'b0,1'b0,8'h00, Z,   1'b1, D12}   // R6
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1;
   logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic          out_en_n = 1'b0, lin_order = 1'b1, sleep = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          drive_en;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) i_pipe_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
      .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
      .out_en_n(out_en_n), .lin_order(lin_order), .sleep(sleep),
      .din(din), .dout(dout), .drive_en(drive_en)
   );

   task automatic check(input int req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      {sel_a_n, sel_b, sel_c_n} = v.sel;
      cpu_strobe_n = v.cpu_n;
      ctl_strobe_n = v.ctl_n;
      step_n       = v.step_n;
      all_wr_n     = v.gw_n;
      lane_wr_n    = v.lw_n;
      lane_sel_n   = v.ls_n;
      out_en_n     = v.oe_n;
      lin_order    = v.lin;
      addr         = v.addr;
      din          = v.din;
   endtask

   task automatic edge_wait();
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      finish_run();
   end

   initial begin
      // R12: reset state
      #(CLK_PERIOD * 2 + CLK_PERIOD/4);
      rst_n = 1'b1;
      check(12, "reset drive_en", {35'd0, drive_en}, Z);
      check(12, "reset dout", dout, Z);
      // R12: continuation edges after reset make no access
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      edge_wait();
      edge_wait();
      check(12, "idle after reset drive_en", {35'd0, drive_en}, Z);

      for (int i = 0; i < N; i++) begin
         apply(TBL[i]);
         edge_wait();
         check(int'(TBL[i].req), $sformatf("row %0d drive_en", i),
               {35'd0, drive_en}, {35'd0, TBL[i].exp_en});
         if (TBL[i].exp_en)
            check(int'(TBL[i].req), $sformatf("row %0d dout", i), dout, TBL[i].exp_q);
      end

      // R11: sleep masks the drive at once, blocks a write, keeps the array
      check(11, "drive before sleep", {35'd0, drive_en}, 36'd1);
      sleep = 1'b1;
      #1;
      check(11, "sleep drive_en async", {35'd0, drive_en}, Z);
      ctl_strobe_n = 1'b0; all_wr_n = 1'b0; addr = 8'h12; din = Z;
      edge_wait();
      check(11, "sleep write drive_en", {35'd0, drive_en}, Z);
      sleep = 1'b0; ctl_strobe_n = 1'b1; all_wr_n = 1'b1; step_n = 1'b1;
      edge_wait();
      check(11, "wake first cycle", {35'd0, drive_en}, Z);
      edge_wait();
      check(11, "word kept through sleep", dout, D12);
      check(11, "drive after sleep", {35'd0, drive_en}, 36'd1);

      finish_run();
   end

endmodule